// File: doc/BRIEF.md
# Configurable Dual-Port Nibble RAM

This block is a small storage tile of 32 words, each 4 bits wide. It has one port that writes and one that reads, and each has its own address. Reads are combinational from the selected address. Writes use an active-low write enable. A configuration pin picks how writes behave. In edge mode a write becomes visible on the read path only after the rising clock edge that captures it. In level mode the addressed word follows the data input for as long as the enable is low, so a read of the same word sees the new data in the same cycle.

A mode pin folds the tile onto one address. In that mode the write address also addresses the read, and the data output stops driving during a write cycle, so the two directions can share one bidirectional pad path. A parameter builds a variant with no separate read address, which works only in that single-address form.

An output-enable pin gates the output. A separate drive flag tells the pad wrapper when to drive and when to leave the line at high impedance. A clear pin zeroes the whole array at a clock edge.

Top module: `nibble_ram_tile`

## Requirements
- R1: After the asynchronous active-low reset, every word reads 0.
- R2: With sync_mode=1, a write (wr_en_n=0) stores din into word wr_addr at the rising edge. A read of that word in the write cycle shows the old content, and reads from the next cycle on show din.
- R3: With sync_mode=0, while wr_en_n=0 a read of word wr_addr shows din in that same cycle (write-through), and the value stays stored after the edge.
- R4: In dual mode (single_port=0), dout shows the word at rd_addr combinationally, whatever write is in progress to a different word.
- R5: A word is not changed by an edge at which wr_en_n=1 or at which a different word is addressed.
- R6: clear=1 at a rising edge sets all words to 0, and it takes priority over a write in the same cycle.
- R7: With oe=0, dout_en=0 and dout=0.
- R8: With single_port=1, the read uses wr_addr and rd_addr is ignored. During a write cycle (wr_en_n=0), dout_en=0 and dout=0.
- R9: With parameter DUAL_PORT=0, the tile always behaves as in single_port=1, whatever the single_port and rd_addr pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, zeroes the array |
| sync_mode | input | 1 | 1 = edge-captured write, 0 = level-sensitive write with write-through |
| single_port | input | 1 | 1 = one shared address and turn-around of the data path |
| wr_addr | input | 5 | Write address (also the read address in single-address mode) |
| rd_addr | input | 5 | Read address in dual mode |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 4 | Write data |
| clear | input | 1 | Zero the whole array at the next rising edge |
| oe | input | 1 | Output enable |
| dout | output | 4 | Read data, 0 when not driving |
| dout_en | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The bench builds two copies with the default geometry of 32 by 4. One copy has DUAL_PORT=1. The other has DUAL_PORT=0 and receives the same stimulus, so the tied-off variant is compared against the single-address reference while its single_port and rd_addr pins toggle freely. Because the geometry is small, directed sweeps reach every word. A long random phase then reaches same-address collisions, mode switches that land between writes, and a clear that coincides with a write.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
  localparam int NRT_ADDR_W = 5;
  localparam int NRT_DATA_W = 4;

  // source of the read address
  typedef enum logic {
    RSRC_READ  = 1'b0,
    RSRC_WRITE = 1'b1
  } rd_src_e;
endpackage

// File: rtl/nrt_wdecode.sv
module nrt_wdecode #(
  parameter int ADDR_W = 5,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [WORDS-1:0]  wstrobe
);
  for (genvar w = 0; w < WORDS; w++) begin : g_dec
    assign wstrobe[w] = !wr_en_n && (wr_addr == ADDR_W'(w));
  end
endmodule

// File: rtl/nrt_store.sv
module nrt_store #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [WORDS-1:0]  wstrobe,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] words [WORDS]
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            words[w] <= '0;
      else if (clear)        words[w] <= '0;
      else if (wstrobe[w])   words[w] <= din;
    end
  end
endmodule

// File: rtl/nrt_readpath.sv
module nrt_readpath #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic [DATA_W-1:0] words [WORDS],
  input  logic [ADDR_W-1:0] rd_sel,
  input  logic              bypass,
  input  logic [DATA_W-1:0] din,
  input  logic              drive,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] picked;
  always_comb begin
    picked = bypass ? din : words[rd_sel];
    dout   = drive ? picked : '0;
  end
endmodule

// File: rtl/nibble_ram_tile.sv
module nibble_ram_tile #(
  parameter int ADDR_W    = nrt_pkg::NRT_ADDR_W,
  parameter int DATA_W    = nrt_pkg::NRT_DATA_W,
  parameter bit DUAL_PORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              single_port,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] din,
  input  logic              clear,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  import nrt_pkg::*;
  localparam int WORDS = 1 << ADDR_W;

  logic [WORDS-1:0]  wstrobe;
  logic [DATA_W-1:0] words [WORDS];
  logic [ADDR_W-1:0] rd_sel;
  rd_src_e           rsrc;
  logic              bypass;

  // the tied-off variant has no separate read address
  if (DUAL_PORT) begin : g_dual
    assign rsrc = single_port ? RSRC_WRITE : RSRC_READ;
  end else begin : g_single
    assign rsrc = RSRC_WRITE;
  end

  assign rd_sel  = (rsrc == RSRC_WRITE) ? wr_addr : rd_addr;
  assign bypass  = !sync_mode && !wr_en_n && (rd_sel == wr_addr);
  assign dout_en = oe && !((rsrc == RSRC_WRITE) && !wr_en_n);

  nrt_wdecode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_n (wr_en_n),
    .wr_addr (wr_addr),
    .wstrobe (wstrobe)
  );

  nrt_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .wstrobe (wstrobe),
    .din     (din),
    .words   (words)
  );

  nrt_readpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .words  (words),
    .rd_sel (rd_sel),
    .bypass (bypass),
    .din    (din),
    .drive  (dout_en),
    .dout   (dout)
  );
endmodule

// File: rtl/nrt_checker.sv
module nrt_checker #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 4,
  parameter bit DUAL_PORT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_mode,
  input logic              single_port,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en_n,
  input logic [DATA_W-1:0] din,
  input logic              clear,
  input logic              oe,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic sp;
  logic [ADDR_W-1:0] ra;
  logic no_fwd;
  assign sp     = single_port || !DUAL_PORT;
  assign ra     = sp ? wr_addr : rd_addr;
  assign no_fwd = wr_en_n || sync_mode || (ra != wr_addr);

  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dout_en && dout == '0));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp && !wr_en_n) |-> !dout_en);

  assert_write_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !wr_en_n && oe && !sp && rd_addr == wr_addr) |-> dout == din);

  assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!wr_en_n && !clear) && dout_en && no_fwd
      && ra == $past(wr_addr)) |-> dout == $past(din));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clear) && dout_en && no_fwd) |-> dout == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en_n && !clear && dout_en) && dout_en && no_fwd
      && $stable(ra)) |-> $stable(dout));
endmodule

bind nibble_ram_tile nrt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUAL_PORT(DUAL_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .single_port(single_port),
  .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_en_n(wr_en_n), .din(din),
  .clear(clear), .oe(oe), .dout(dout), .dout_en(dout_en)
);

// File: tb/sim_nibble_ram_tile.sv
module sim_nibble_ram_tile;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int NW = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic sync_mode = 1, single_port = 0, wr_en_n = 1, clear = 0, oe = 1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, dout1;
  logic dout_en, dout_en1;

  int checks = 0, errors = 0;
  bit done = 0;
  int mem [NW];

  always #5 clk = ~clk;

  nibble_ram_tile #(.ADDR_W(AW), .DATA_W(DW), .DUAL_PORT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .single_port(single_port),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_en_n(wr_en_n), .din(din),
    .clear(clear), .oe(oe), .dout(dout), .dout_en(dout_en));

  nibble_ram_tile #(.ADDR_W(AW), .DATA_W(DW), .DUAL_PORT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .single_port(single_port),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_en_n(wr_en_n), .din(din),
    .clear(clear), .oe(oe), .dout(dout1), .dout_en(dout_en1));

  function automatic int expect_val(bit sp, output bit en);
    int a;
    a  = sp ? int'(wr_addr) : int'(rd_addr);
    en = oe && !(sp && !wr_en_n);
    if (!en) return 0;
    if (!sync_mode && !wr_en_n && a == int'(wr_addr)) return int'(din);
    return mem[a];
  endfunction

  task automatic check(string tag);
    bit e0, e1;
    int x0, x1;
    x0 = expect_val(single_port, e0);
    x1 = expect_val(1'b1, e1);
    checks++;
    if (int'(dout) != x0 || dout_en != e0) begin
      errors++;
      $display("FAIL %s u0 dout=%0d en=%0b expected %0d en=%0b", tag, dout, dout_en, x0, e0);
    end
    checks++;
    if (int'(dout1) != x1 || dout_en1 != e1) begin
      errors++;
      $display("FAIL R9 (%s) u1 dout=%0d en=%0b expected %0d en=%0b", tag, dout1, dout_en1, x1, e1);
    end
  endtask

  // drive after falling edge, compare before rising edge, then update the model
  task automatic step(string tag, bit sm, bit sp, bit we_n, int wa, int ra,
                      int d, bit clr, bit o);
    @(negedge clk);
    sync_mode = sm; single_port = sp; wr_en_n = we_n; wr_addr = AW'(wa);
    rd_addr = AW'(ra); din = DW'(d); clear = clr; oe = o;
    #2;
    check(tag);
    @(posedge clk);
    if (clr) foreach (mem[i]) mem[i] = 0;
    else if (!we_n) mem[wa] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mem[i]) mem[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: all words zero after reset
    for (int a = 0; a < NW; a++) step("R1", 1, 0, 1, 0, a, 0, 0, 1);
    // R2: edge writes, old value in write cycle, new after
    for (int a = 0; a < NW; a++) step("R2", 1, 0, 0, a, a, (a * 7 + 3) & 15, 0, 1);
    for (int a = 0; a < NW; a++) step("R2", 1, 0, 1, 0, a, 0, 0, 1);
    // R4: reads of other words during writes
    for (int a = 0; a < 8; a++) step("R4", 1, 0, 0, a, a + 16, a, 0, 1);
    // R5: disabled writes leave words alone
    for (int a = 0; a < 8; a++) step("R5", 1, 0, 1, a, a, 15 - a, 0, 1);
    for (int a = 0; a < 8; a++) step("R5", 1, 0, 1, 0, a, 0, 0, 1);
    // R3: level mode write-through
    for (int a = 0; a < 8; a++) step("R3", 0, 0, 0, a, a, a ^ 9, 0, 1);
    for (int a = 0; a < 8; a++) step("R3", 0, 0, 1, 0, a, 0, 0, 1);
    // R7: output gated
    step("R7", 0, 0, 0, 3, 3, 5, 0, 0);
    step("R7", 1, 0, 1, 0, 3, 0, 0, 0);
    // R8: single address, turn-around
    step("R8", 1, 1, 0, 9, 2, 12, 0, 1);
    step("R8", 1, 1, 1, 9, 2, 0, 0, 1);
    step("R8", 0, 1, 0, 9, 9, 6, 0, 1);
    step("R8", 0, 1, 1, 9, 30, 0, 0, 1);
    // R6: clear with a coincident write
    step("R6", 1, 0, 0, 4, 4, 11, 1, 1);
    for (int a = 0; a < NW; a++) step("R6", 1, 0, 1, 0, a, 0, 0, 1);
    // R9 and all: random mix
    for (int n = 0; n < 3000; n++)
      step("R9", 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % NW),
           int'($urandom % NW), int'($urandom % 16), ($urandom % 40) == 0,
           ($urandom % 8) != 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule